// File: doc/BRIEF.md
# RS-485 Driver-Enable Sequencer

This block drives the driver-enable pin of an RS-485 line transceiver from the state of a UART transmitter. The pin asserts as soon as a character is waiting to be sent, so the line driver is switched on before the start bit appears. It stays asserted while characters shift out. After the final stop bit it remains asserted for a programmable number of whole bit periods, from 0 to 255, and is then released.

The transmitter supplies three signals. The first is a level that is high while a character waits to be sent. The second is a one-cycle pulse when the stop bit of a character completes. The third is a one-cycle tick once per bit period. The hold-off length is counted down by an 8-bit counter loaded at the end of every transmission. A character that arrives during the hold-off cancels it, and the pin stays asserted without a gap. A polarity input selects whether the asserted level is low or high.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no character waiting, the pin is at the released level and no hold-off is running.
- R2: With `invert_i` = 0 the asserted level is 0 and the released level is 1. With `invert_i` = 1 the asserted level is 1 and the released level is 0.
- R3: The pin takes the asserted level in the same clock cycle that `tx_pending_i` is 1, before any registered state has changed.
- R4: Once asserted, the pin stays asserted after `tx_pending_i` falls, until a `stop_done_i` pulse arrives with `tx_pending_i` at 0.
- R5: With a hold value N from 1 to 255, the pin is released in the cycle after the Nth `baud_tick_i` that follows the `stop_done_i` cycle. A tick in the same cycle as `stop_done_i` is not counted.
- R6: With a hold value of 0, the pin is released in the cycle right after the `stop_done_i` pulse.
- R7: The hold-off advances only on `baud_tick_i`. Without ticks the pin stays asserted for any number of cycles.
- R8: When `tx_pending_i` is 1 during a hold-off, including the cycle of its last tick, the hold-off is cancelled and the pin stays asserted continuously. The next end of transmission restarts the full programmed delay.
- R9: When `stop_done_i` arrives while `tx_pending_i` is 1 (back-to-back characters), no hold-off starts and the pin stays asserted.
- R10: The hold value is captured at the `stop_done_i` pulse. Later changes of `hold_bits_i` do not alter a hold-off that is already running.
- R11: A `stop_done_i` pulse while the pin is released has no effect, and the pin stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_pending_i | input | 1 | A character is waiting to be transmitted |
| stop_done_i | input | 1 | One-cycle pulse when a stop bit completes |
| baud_tick_i | input | 1 | One-cycle pulse once per bit period |
| hold_bits_i | input | CNT_W | Hold-off after the last stop bit, in bit periods |
| invert_i | input | 1 | Selects the asserted level of the pin (0: low, 1: high) |
| dir_pin_o | output | 1 | Transceiver driver-enable pin |

## Verification
Two events can fall in the same cycle. One is the expiry of the hold-off on its final baud tick. The other is a newly waiting character that cancels it. The bench drives `tx_pending_i` high in exactly the cycle of the last tick and expects the pin to stay asserted in that cycle and the next one, with no released cycle between them. A second case puts `stop_done_i` and `tx_pending_i` in the same cycle and expects no hold-off to start. A later end of transmission must still count the full programmed delay.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_SEND = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    typedef struct packed {
        dir_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/rs485_hold_timer.sv
module rs485_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = ZERO;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != ZERO)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = tick_i && (cnt_q == ONE) && !load_i && !clear_i;
    assign count_o  = cnt_q;

    // R10: a loaded value is captured as given
    a_r10_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cnt_q == $past(load_val_i)));

    // R7: count holds without a tick
    a_r7_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rs485_dir_seq.sv
module rs485_dir_seq
    import rs485_dir_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_pending_i,
    input  logic             stop_done_i,
    input  logic [CNT_W-1:0] hold_bits_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic             clear_o,
    output logic             drive_o,
    output logic             hold_o
);
    seq_regs_t r_d, r_q;
    logic      zero_hold;

    assign zero_hold = (hold_bits_i == '0);

    always_comb begin
        r_d     = r_q;
        load_o  = 1'b0;
        clear_o = 1'b0;
        unique case (r_q.state)
            DIR_IDLE: begin
                if (tx_pending_i) r_d.state = DIR_SEND;
            end
            DIR_SEND: begin
                if (stop_done_i && !tx_pending_i) begin
                    if (zero_hold) begin
                        r_d.state = DIR_IDLE;
                    end else begin
                        r_d.state = DIR_HOLD;
                        load_o    = 1'b1;
                    end
                end
            end
            DIR_HOLD: begin
                if (tx_pending_i) begin
                    r_d.state = DIR_SEND;
                    clear_o   = 1'b1;
                end else if (stop_done_i) begin
                    if (zero_hold) begin
                        r_d.state = DIR_IDLE;
                        clear_o   = 1'b1;
                    end else begin
                        load_o    = 1'b1;
                    end
                end else if (expire_i) begin
                    r_d.state = DIR_IDLE;
                end
            end
            default: r_d.state = DIR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: DIR_IDLE};
        else        r_q <= r_d;
    end

    assign drive_o = tx_pending_i || (r_q.state != DIR_IDLE);
    assign hold_o  = (r_q.state == DIR_HOLD);

    // R8: a waiting character cancels the hold-off
    a_r8_cancel_to_send: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DIR_HOLD && tx_pending_i) |=> (r_q.state == DIR_SEND));

    // R9: back-to-back characters keep the sender active
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DIR_SEND && stop_done_i && tx_pending_i) |=> (r_q.state == DIR_SEND));

    // R11: a stop pulse while idle is ignored
    a_r11_idle_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DIR_IDLE && stop_done_i && !tx_pending_i) |=> (r_q.state == DIR_IDLE));

endmodule

// File: rtl/rs485_pin_stage.sv
module rs485_pin_stage (
    input  logic drive_i,
    input  logic invert_i,
    output logic pin_o
);
    always_comb begin
        pin_o = drive_i ? invert_i : !invert_i;
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_pending_i,
    input  logic             stop_done_i,
    input  logic             baud_tick_i,
    input  logic [CNT_W-1:0] hold_bits_i,
    input  logic             invert_i,
    output logic             dir_pin_o
);
    logic             load_s, clear_s, expire_s, drive_s, hold_s;
    logic [CNT_W-1:0] count_s;

    rs485_dir_seq #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_pending_i (tx_pending_i),
        .stop_done_i  (stop_done_i),
        .hold_bits_i  (hold_bits_i),
        .expire_i     (expire_s),
        .load_o       (load_s),
        .clear_o      (clear_s),
        .drive_o      (drive_s),
        .hold_o       (hold_s)
    );

    rs485_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_s),
        .clear_i    (clear_s),
        .load_val_i (hold_bits_i),
        .tick_i     (baud_tick_i),
        .expire_o   (expire_s),
        .count_o    (count_s)
    );

    rs485_pin_stage u_pin (
        .drive_i  (drive_s),
        .invert_i (invert_i),
        .pin_o    (dir_pin_o)
    );

    // R5: a running hold-off never sits at a zero count
    a_r5_no_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |-> (count_s != '0));

    // R3: a waiting character always shows the asserted level
    a_r3_pending_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending_i |-> (dir_pin_o == invert_i));

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_pending = 1'b0;
    logic       stop_done = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] hold_bits = 8'd0;
    logic       invert = 1'b0;
    logic       dir_pin;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl #(.CNT_W(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_pending_i (tx_pending),
        .stop_done_i  (stop_done),
        .baud_tick_i  (baud_tick),
        .hold_bits_i  (hold_bits),
        .invert_i     (invert),
        .dir_pin_o    (dir_pin)
    );

    // monitor: compares expected items at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (dir_pin !== it.exp) begin
                n_bad++;
                $display("FAIL %s: dir_pin=%b expected %b", it.tag, dir_pin, it.exp);
            end
        end
    end

    // R2 encoding: asserted level equals invert, released is its complement
    task automatic exp_on(input string tag);
        item_t it;
        it.exp = invert;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_off(input string tag);
        item_t it;
        it.exp = ~invert;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drv(input logic p, input logic s, input logic t);
        tx_pending = p;
        stop_done  = s;
        baud_tick  = t;
    endtask

    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    // one character: waits one cycle, then shifts for two cycles
    task automatic frame_start(input string tag);
        drv(1, 0, 0); exp_on({tag, " R3 same-cycle assert"}); adv();
        drv(0, 0, 1); exp_on({tag, " R4 held while shifting"}); adv();
        drv(0, 0, 0); exp_on({tag, " R4 held while shifting"}); adv();
    endtask

    // end of transmission followed by a hold-off of n ticks, one per cycle
    task automatic hold_run(input int n, input string tag);
        drv(0, 1, 0); exp_on({tag, " stop cycle"}); adv();
        for (int i = 1; i <= n; i++) begin
            drv(0, 0, 1); exp_on({tag, " R5 during hold-off"}); adv();
        end
        drv(0, 0, 0); exp_off({tag, " R5 released after last tick"}); adv();
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        exp_off("R1 released during reset");
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        drv(0, 0, 0); exp_off("R1 released after reset"); adv();

        // R6 / R11: zero delay, polarity 0
        frame_start("hold0");
        drv(0, 1, 0); exp_on("R6 asserted in stop cycle"); adv();
        drv(0, 0, 0); exp_off("R6 released cycle after stop"); adv();
        drv(0, 1, 1); exp_off("R11 stop while idle"); adv();
        drv(0, 0, 0); exp_off("R11 still released"); adv();

        // R5: delay 1, tick in stop cycle not counted
        hold_bits = 8'd1;
        frame_start("hold1");
        drv(0, 1, 1); exp_on("R5 stop with tick"); adv();
        drv(0, 0, 0); exp_on("R5 tick in stop cycle ignored"); adv();
        drv(0, 0, 1); exp_on("R5 last tick cycle"); adv();
        drv(0, 0, 0); exp_off("R5 released after one tick"); adv();

        // R5 / R7: delay 255 with a long gap without ticks
        hold_bits = 8'd255;
        frame_start("hold255");
        drv(0, 1, 0); exp_on("R5 stop 255"); adv();
        for (int i = 0; i < 60; i++) begin
            drv(0, 0, 0); exp_on("R7 no ticks keeps asserted"); adv();
        end
        for (int i = 1; i <= 255; i++) begin
            drv(0, 0, 1); exp_on("R5 hold 255 counting"); adv();
        end
        drv(0, 0, 0); exp_off("R5 released after 255 ticks"); adv();

        // R2: inverted polarity
        invert = 1'b1;
        drv(0, 0, 0); exp_off("R2 released level with invert"); adv();
        hold_bits = 8'd3;
        frame_start("inv");
        hold_run(3, "R2 inv hold3");

        // R8: cancel in the cycle of the last tick, then full restart
        hold_bits = 8'd2;
        frame_start("cancel");
        drv(0, 1, 0); exp_on("R8 stop"); adv();
        drv(0, 0, 1); exp_on("R8 first tick"); adv();
        drv(1, 0, 1); exp_on("R8 pending on last tick"); adv();
        drv(0, 0, 0); exp_on("R8 no gap after cancel"); adv();
        drv(0, 0, 1); exp_on("R8 still sending"); adv();
        hold_bits = 8'd5;
        hold_run(5, "R8 restart full delay");

        // R9: back-to-back characters
        invert = 1'b0;
        hold_bits = 8'd0;
        frame_start("b2b");
        drv(1, 1, 1); exp_on("R9 stop with pending"); adv();
        for (int i = 0; i < 4; i++) begin
            drv(0, 0, 1); exp_on("R9 no hold-off started"); adv();
        end
        drv(0, 1, 0); exp_on("R9 final stop"); adv();
        drv(0, 0, 0); exp_off("R9 released with zero hold"); adv();

        // R10: hold value captured at stop pulse
        hold_bits = 8'd3;
        frame_start("capture");
        drv(0, 1, 0); exp_on("R10 stop"); adv();
        hold_bits = 8'd0;
        drv(0, 0, 1); exp_on("R10 hold change to 0 ignored"); adv();
        hold_bits = 8'd200;
        drv(0, 0, 1); exp_on("R10 hold change to 200 ignored"); adv();
        drv(0, 0, 1); exp_on("R10 third tick"); adv();
        drv(0, 0, 0); exp_off("R10 released after captured 3"); adv();

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule